// File: doc/BRIEF.md
# Trigger-Line Play Mode Controller

This block is the front end of a standalone message playback engine. It watches a bank of active-low trigger lines while the engine is idle. When one line has been held low long enough, it records that line's message number, signals the message locator with a one-cycle start strobe, and enters play mode. During play it pulls the chosen line low as a busy indicator and holds an active-low memory read enable asserted. Play mode ends when the engine reports end of message, or when reset is raised.

Each trigger line is an open-drain pin. The pin is modelled as an output enable and a data value per line, and the data value is always 0. A line is only an input while the controller is idle. Triggers go through a two-flop synchroniser and must then stay low for `HOLD_CYCLES` consecutive system clocks before they are accepted. `HOLD_CYCLES` should be chosen to cover the minimum trigger pulse width at the system clock rate, and it must be at least 3. With that minimum, the two stale low samples of a line the controller has just released cannot start the line again.

The start strobe and the message index are plain control outputs with no back-pressure. The locator must take the strobe in the cycle it is high, and it must read `msg_idx` while `read_n` is low.

Top module: `trig_mode_ctrl`

## Requirements
- R1: While `rst` is high, `read_n` is 1, `trig_oe` and `start_pulse` are 0 and `msg_idx` is 0. A trigger line held low during reset starts nothing, including after reset is released, provided the line goes high again by then.
- R2: In idle, a line k (bit k-1, with k from 1 to NUM_LINES) held low for exactly `HOLD_CYCLES` clock edges is accepted. `read_n` goes low and `msg_idx` equals k starting with the cycle after the (`HOLD_CYCLES`+2)-th edge counted from the first edge that samples the line low, and not one cycle earlier.
- R3: A low pulse that lasts `HOLD_CYCLES`-1 edges is ignored, and the block stays idle.
- R4: Throughout play, `trig_oe` has only bit k-1 set, `trig_do` is all zero, and `msg_idx` does not change.
- R5: If several lines become qualified in the same cycle, the lowest-numbered line is selected.
- R6: Trigger pulses on other lines during play are ignored. The index stays the same and no further start strobe occurs.
- R7: When `eom` is high at a clock edge during play, the outputs after that edge are `read_n`=1, `trig_oe`=0 and `msg_idx`=0.
- R8: `eom` in idle has no effect, and `read_n` stays 1.
- R9: `start_pulse` is high for exactly one cycle per accepted message. That cycle is the first cycle of play.
- R10: Raising `rst` during play returns the block to idle at the next edge and releases the busy line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; forces idle while high |
| trig_in_n | input | NUM_LINES | Sampled level of each trigger pin, active low |
| eom | input | 1 | End of message from the playback engine |
| trig_oe | output | NUM_LINES | Per-pin output enable; pulls the busy line low |
| trig_do | output | NUM_LINES | Per-pin driven value (always 0) |
| read_n | output | 1 | Active-low memory read enable, low for all of play mode |
| msg_idx | output | IDX_W | Selected message number, 1-based; 0 in idle |
| start_pulse | output | 1 | One-cycle strobe to the message locator |

## Verification
The bench uses `NUM_LINES`=10 and `HOLD_CYCLES`=5. This makes the accept/reject boundary reachable with pulses of five and four cycles, so the start cycle can be checked exactly. It also covers both extreme lines, 1 and 10. Since the busy line is fed back through a wired-AND pin model, the bench also checks that the controller's own pull-down after release does not start the line again.

// File: rtl/trig_pkg.sv
package trig_pkg;
  typedef enum logic {
    MODE_IDLE = 1'b0,
    MODE_PLAY = 1'b1
  } mode_e;
endpackage

// File: rtl/trig_sync.sv
module trig_sync #(
  parameter int NUM_LINES = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] pin_n,
  output logic [NUM_LINES-1:0] low_o
);
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic s1_n, s2_n;
    always_ff @(posedge clk) begin
      if (rst) begin
        s1_n <= 1'b1;
        s2_n <= 1'b1;
      end else begin
        s1_n <= pin_n[g];
        s2_n <= s1_n;
      end
    end
    assign low_o[g] = ~s2_n;
  end
endmodule

// File: rtl/trig_qual.sv
module trig_qual #(
  parameter int NUM_LINES   = 10,
  parameter int HOLD_CYCLES = 420,
  localparam int CW = $clog2(HOLD_CYCLES + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 arm,
  input  logic [NUM_LINES-1:0] low_i,
  output logic [NUM_LINES-1:0] qual_o
);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic [CW-1:0] cnt;
    always_ff @(posedge clk) begin
      if (rst || !arm || !low_i[g]) cnt <= '0;
      else if (cnt != LAST) cnt <= cnt + 1'b1;
    end
    assign qual_o[g] = arm && low_i[g] && (cnt == LAST);

    if (HOLD_CYCLES > 1) begin : g_chk
      p_qual_history_r3: assert property (@(posedge clk) disable iff (rst)
        qual_o[g] |-> $past(low_i[g]));
    end
  end
endmodule

// File: rtl/trig_pick.sv
module trig_pick #(
  parameter int NUM_LINES = 10,
  localparam int IDX_W = $clog2(NUM_LINES + 1)
) (
  input  logic [NUM_LINES-1:0] req,
  output logic                 hit,
  output logic [IDX_W-1:0]     idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (req[i]) begin
        hit = 1'b1;
        idx = IDX_W'(i + 1);
      end
    end
  end
endmodule

// File: rtl/trig_mode_ctrl.sv
module trig_mode_ctrl
  import trig_pkg::*;
#(
  parameter int NUM_LINES   = 10,
  parameter int HOLD_CYCLES = 420,
  localparam int IDX_W = $clog2(NUM_LINES + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] trig_in_n,
  input  logic                 eom,
  output logic [NUM_LINES-1:0] trig_oe,
  output logic [NUM_LINES-1:0] trig_do,
  output logic                 read_n,
  output logic [IDX_W-1:0]     msg_idx,
  output logic                 start_pulse
);
  mode_e             mode_q;
  logic [IDX_W-1:0]  idx_q;
  logic              start_q;
  logic [NUM_LINES-1:0] low_s, qual;
  logic              hit;
  logic [IDX_W-1:0]  pick_idx;

  trig_sync #(.NUM_LINES(NUM_LINES)) u_sync (
    .clk(clk), .rst(rst), .pin_n(trig_in_n), .low_o(low_s));

  trig_qual #(.NUM_LINES(NUM_LINES), .HOLD_CYCLES(HOLD_CYCLES)) u_qual (
    .clk(clk), .rst(rst), .arm(mode_q == MODE_IDLE), .low_i(low_s), .qual_o(qual));

  trig_pick #(.NUM_LINES(NUM_LINES)) u_pick (
    .req(qual), .hit(hit), .idx(pick_idx));

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= MODE_IDLE;
      idx_q   <= '0;
      start_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      unique case (mode_q)
        MODE_IDLE: if (hit) begin
          mode_q  <= MODE_PLAY;
          idx_q   <= pick_idx;
          start_q <= 1'b1;
        end
        MODE_PLAY: if (eom) begin
          mode_q <= MODE_IDLE;
          idx_q  <= '0;
        end
        default: mode_q <= MODE_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_pin
    assign trig_oe[g] = (mode_q == MODE_PLAY) && (idx_q == IDX_W'(g + 1));
  end
  assign trig_do     = '0;
  assign read_n      = (mode_q != MODE_PLAY);
  assign msg_idx     = idx_q;
  assign start_pulse = start_q;

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (read_n && trig_oe == '0 && !start_pulse));
  p_busy_line_r4: assert property (@(posedge clk) disable iff (rst)
    !read_n |-> $onehot(trig_oe));
  p_idx_stable_r4: assert property (@(posedge clk) disable iff (rst)
    (!read_n && !$past(read_n)) |-> $stable(msg_idx));
  p_release_r7: assert property (@(posedge clk) disable iff (rst)
    (!read_n && eom) |=> (read_n && trig_oe == '0));
  p_start_from_idle_r9: assert property (@(posedge clk) disable iff (rst)
    start_pulse |-> ($past(read_n) && !read_n));
  p_start_single_r9: assert property (@(posedge clk) disable iff (rst)
    start_pulse |=> !start_pulse);
endmodule

// File: tb/trig_mode_ctrl_tb.sv
module trig_mode_ctrl_tb;
  localparam int N = 10;
  localparam int HOLD = 5;
  localparam int IW = $clog2(N + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic eom = 1'b0;
  logic [N-1:0] ext_n = '1;
  logic [N-1:0] trig_in_n, trig_oe, trig_do;
  logic read_n, start_pulse;
  logic [IW-1:0] msg_idx;

  int n_chk = 0;
  int n_err = 0;
  int n_starts = 0;
  int exp_q[$];

  always #2 clk = ~clk;
  assign trig_in_n = ext_n & ~trig_oe;

  trig_mode_ctrl #(.NUM_LINES(N), .HOLD_CYCLES(HOLD)) u_dut (
    .clk(clk), .rst(rst), .trig_in_n(trig_in_n), .eom(eom),
    .trig_oe(trig_oe), .trig_do(trig_do), .read_n(read_n),
    .msg_idx(msg_idx), .start_pulse(start_pulse));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: scoreboard pop on each start strobe
  always @(negedge clk) begin
    if (!rst && start_pulse) begin
      n_starts++;
      if (exp_q.size() == 0) chk(1'b0, "R6 unexpected start", int'(msg_idx), 0);
      else begin
        int e;
        e = exp_q.pop_front();
        chk(msg_idx == IW'(e), "R5 start index", int'(msg_idx), e);
      end
    end
  end

  task automatic accept(input logic [N-1:0] lines, input int k);
    exp_q.push_back(k);
    @(negedge clk) ext_n = ~lines;
    repeat (HOLD + 1) @(posedge clk);
    @(negedge clk) chk(read_n == 1'b1, "R2 not early", int'(read_n), 1);
    @(posedge clk);
    @(negedge clk);
    chk(read_n == 1'b0, "R2 read_n low", int'(read_n), 0);
    chk(start_pulse == 1'b1, "R9 start high", int'(start_pulse), 1);
    chk(msg_idx == IW'(k), "R2 idx", int'(msg_idx), k);
    ext_n = '1;
    @(negedge clk) chk(start_pulse == 1'b0, "R9 start one cycle", int'(start_pulse), 0);
    chk(trig_oe == N'(1) << (k - 1), "R4 oe onehot", int'(trig_oe), 1 << (k - 1));
    chk(trig_do == '0, "R4 do zero", int'(trig_do), 0);
  endtask

  task automatic finish_msg(input int k);
    repeat (6) @(negedge clk);
    chk(msg_idx == IW'(k), "R4 idx stable", int'(msg_idx), k);
    eom = 1'b1;
    @(negedge clk) eom = 1'b0;
    chk(read_n == 1'b1, "R7 read_n released", int'(read_n), 1);
    chk(trig_oe == '0, "R7 oe released", int'(trig_oe), 0);
    chk(msg_idx == '0, "R7 idx cleared", int'(msg_idx), 0);
    repeat (HOLD + 4) @(negedge clk);
    chk(read_n == 1'b1, "R7 no self retrigger", int'(read_n), 1);
  endtask

  task automatic pulse(input int k, input int len);
    @(negedge clk) ext_n[k-1] = 1'b0;
    repeat (len) @(posedge clk);
    @(negedge clk) ext_n[k-1] = 1'b1;
  endtask

  initial begin
    #(4 * 150000);
    chk(1'b0, "watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    ext_n[1] = 1'b0;
    repeat (HOLD + 4) @(negedge clk);
    chk(read_n == 1'b1 && trig_oe == '0, "R1 idle in reset", int'(read_n), 1);
    chk(msg_idx == '0 && !start_pulse, "R1 idx/start zero", int'(msg_idx), 0);
    ext_n[1] = 1'b1;
    rst = 1'b0;
    repeat (HOLD + 4) @(negedge clk);
    chk(read_n == 1'b1, "R1 no start after reset", int'(read_n), 1);

    accept(N'(1) << 2, 3);
    pulse(1, HOLD + 3);
    pulse(8, HOLD + 3);
    chk(msg_idx == IW'(3), "R6 idx kept", int'(msg_idx), 3);
    chk(trig_oe == N'(4), "R6 oe kept", int'(trig_oe), 4);
    finish_msg(3);

    pulse(5, HOLD - 1);
    repeat (HOLD + 4) @(negedge clk);
    chk(read_n == 1'b1, "R3 short pulse ignored", int'(read_n), 1);

    exp_q.push_back(10);
    pulse(10, HOLD);
    repeat (3) @(negedge clk);
    chk(read_n == 1'b0 && msg_idx == IW'(10), "R2 exact hold accepted", int'(msg_idx), 10);
    finish_msg(10);

    eom = 1'b1;
    repeat (3) @(negedge clk);
    eom = 1'b0;
    chk(read_n == 1'b1 && trig_oe == '0, "R8 eom idle ignored", int'(read_n), 1);

    accept((N'(1) << 6) | (N'(1) << 3) | (N'(1) << 8), 4);
    finish_msg(4);

    accept(N'(1), 1);
    finish_msg(1);

    accept(N'(1) << 5, 6);
    rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    chk(read_n == 1'b1 && trig_oe == '0, "R10 reset in play", int'(trig_oe), 0);
    repeat (HOLD + 4) @(negedge clk);
    chk(read_n == 1'b1, "R10 stays idle", int'(read_n), 1);

    chk(exp_q.size() == 0, "R9 all starts seen", exp_q.size(), 0);
    chk(n_starts == 5, "R9 start count", n_starts, 5);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule